// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block is the control unit of a single-cycle 32-bit processor. It takes the instruction word fetched this cycle, together with the processor reset, an interrupt request and the zero flag from the ALU subtraction. From these it produces, in the same cycle and with no internal state, every select and enable that steers the datapath. The outputs are the next-PC choice, immediate extension, register write address and write data source, the ALU function code, the memory write strobe, the register-file write enable and the two ALU operand selects.

The decoder reads only the major opcode (bits 31:26) and, when that is zero, the function field (bits 5:0). Branch conditions are resolved inside the block from the zero flag, so the PC multiplexer needs no logic of its own. A priority stage lets reset, then an interrupt, then an unrecognised encoding replace the normal decode. The interrupt and bad-encoding cases save the return address in register 27.

Top module: `scdec_top`

## Requirements
- R1: While `rst_n` is low, `pc_sel` is 4, `mem_we` and `rf_we` are 0, and every other output is 0, whatever the instruction, `irq` and `alu_zero` are.
- R2: With `rst_n` high and `irq` high, `pc_sel` is 6, `wa_sel` is 3 (register 27), `wd_sel` is 0 (PC+4) and `rf_we` is 1. Every other output is 0.
- R3: With `rst_n` high and `irq` low, an opcode or R-type function value outside the set listed in R4 to R11 gives `pc_sel` 5, `wa_sel` 3, `wd_sel` 0 and `rf_we` 1. Every other output, including `mem_we`, is 0.
- R4: Opcode 0 with function 0x20/0x21 (add), 0x22/0x23 (subtract), 0x24 (and), 0x25 (or), 0x26 (xor), 0x27 (nor), 0x2A (signed less-than) or 0x2B (unsigned less-than) writes rd from the ALU: `wa_sel` 0, `wd_sel` 1, `rf_we` 1, both operand selects 0. `alu_fn` is {sub, mode[1:0], shift, math} with these codes: add 00001, subtract 10001, and 00000, or 00100, xor 01000, nor 01100, signed less-than 10011, unsigned less-than 10111.
- R5: Opcode 0 with function 0x00, 0x02 or 0x03 (shift left, logical right, arithmetic right by the shamt field) sets `a_sel` 1. Functions 0x04, 0x06 and 0x07 (the same shifts by rs) set `a_sel` 0. `alu_fn` is 00010, 00110 and 01110 respectively. The write goes to rd from the ALU.
- R6: Opcodes 0x08/0x09 (add), 0x0A/0x0B (signed/unsigned less-than), 0x0C (and), 0x0D (or) and 0x0E (xor) write rt (`wa_sel` 1) from the ALU with `b_sel` 1. `sext` is 0 for 0x0C, 0x0D and 0x0E and 1 for the others. `alu_fn` follows R4.
- R7: Opcode 0x0F (load upper) sets `a_sel` 2 (constant 16), `b_sel` 1, `sext` 0, `alu_fn` 00010, `wa_sel` 1, `wd_sel` 1 and `rf_we` 1.
- R8: Opcode 0x23 (load) sets `wa_sel` 1, `wd_sel` 2 (memory data), `rf_we` 1 and `mem_we` 0. Opcode 0x2B (store) sets `mem_we` 1 and `rf_we` 0. Both use `alu_fn` 00001, `b_sel` 1 and `sext` 1.
- R9: Opcode 0x04 (branch if equal) gives `pc_sel` 1 when `alu_zero` is 1 and 0 otherwise. Opcode 0x05 (branch if not equal) gives the inverse. Both set `alu_fn` 10001, `sext` 1 and `rf_we` 0.
- R10: Opcode 0x02 (jump) sets `pc_sel` 2 with no write. Opcode 0x03 (jump and link) sets `pc_sel` 2, `wa_sel` 2 (register 31), `wd_sel` 0 and `rf_we` 1.
- R11: Opcode 0 with function 0x08 sets `pc_sel` 3 (register target) with no write. Function 0x09 also sets `wa_sel` 0, `wd_sel` 0 and `rf_we` 1.
- R12: An output not given a value in the requirement for the decoded case is 0, and `pc_sel` is 0 (PC+4) for every valid non-control-flow instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word being executed |
| rst_n | input | 1 | Active-low processor reset, highest priority |
| irq | input | 1 | Interrupt request |
| alu_zero | input | 1 | Zero flag of the ALU result |
| pc_sel | output | 3 | Next PC: 0 PC+4, 1 branch, 2 jump, 3 register, 4 reset, 5 bad encoding, 6 interrupt |
| sext | output | 1 | Sign-extend the 16-bit immediate when 1 |
| wa_sel | output | 2 | Write address: 0 rd, 1 rt, 2 reg 31, 3 reg 27 |
| wd_sel | output | 2 | Write data: 0 PC+4, 1 ALU, 2 memory |
| alu_fn | output | 5 | ALU function code |
| mem_we | output | 1 | Data memory write strobe |
| rf_we | output | 1 | Register-file write enable |
| a_sel | output | 2 | ALU A: 0 rs, 1 shamt, 2 constant 16 |
| b_sel | output | 1 | ALU B: 0 rt, 1 immediate |

## Verification
The block holds no state, so a wrong table entry or a wrong override shows at the ports in the same evaluation as the instruction that selects it. A mistake in one table row shows only for that opcode or function value. Faults in the branch stage show only when the zero flag takes the value that should flip the choice. Faults in the priority stage show only when reset, interrupt and a bad encoding occur together. For that reason the stimulus crosses each valid encoding with both flag values and all reset and interrupt combinations, and adds fully random words that land mostly on invalid encodings.

// File: rtl/scdec_pkg.sv
// Package: shared widths, encodings and the control-word type for the
// single-cycle decoder. Assumes the 6-bit opcode / 6-bit function layout.
package scdec_pkg;

    localparam int INSTR_W  = 32;
    localparam int OP_W     = 6;
    localparam int FN_W     = 6;
    localparam int OP_HI    = INSTR_W - 1;
    localparam int OP_LO    = INSTR_W - OP_W;
    localparam int ALUFN_W  = 5;
    localparam int PCSEL_W  = 3;
    localparam int SEL_W    = 2;

    typedef logic [OP_W-1:0]    op_t;
    typedef logic [FN_W-1:0]    fn_t;
    typedef logic [ALUFN_W-1:0] alufn_t;
    typedef logic [PCSEL_W-1:0] pcsel_t;
    typedef logic [SEL_W-1:0]   sel_t;

    // Major opcodes
    localparam op_t OP_RTYPE = 6'h00;
    localparam op_t OP_JMP   = 6'h02;
    localparam op_t OP_JAL   = 6'h03;
    localparam op_t OP_BEQ   = 6'h04;
    localparam op_t OP_BNE   = 6'h05;
    localparam op_t OP_ADDI  = 6'h08;
    localparam op_t OP_ADDIU = 6'h09;
    localparam op_t OP_SLTI  = 6'h0A;
    localparam op_t OP_SLTIU = 6'h0B;
    localparam op_t OP_ANDI  = 6'h0C;
    localparam op_t OP_ORI   = 6'h0D;
    localparam op_t OP_XORI  = 6'h0E;
    localparam op_t OP_LUI   = 6'h0F;
    localparam op_t OP_LOAD  = 6'h23;
    localparam op_t OP_STORE = 6'h2B;

    // R-type function codes
    localparam fn_t FN_SLL  = 6'h00;
    localparam fn_t FN_SRL  = 6'h02;
    localparam fn_t FN_SRA  = 6'h03;
    localparam fn_t FN_SLLV = 6'h04;
    localparam fn_t FN_SRLV = 6'h06;
    localparam fn_t FN_SRAV = 6'h07;
    localparam fn_t FN_JR   = 6'h08;
    localparam fn_t FN_JALR = 6'h09;
    localparam fn_t FN_ADD  = 6'h20;
    localparam fn_t FN_ADDU = 6'h21;
    localparam fn_t FN_SUB  = 6'h22;
    localparam fn_t FN_SUBU = 6'h23;
    localparam fn_t FN_AND  = 6'h24;
    localparam fn_t FN_OR   = 6'h25;
    localparam fn_t FN_XOR  = 6'h26;
    localparam fn_t FN_NOR  = 6'h27;
    localparam fn_t FN_SLT  = 6'h2A;
    localparam fn_t FN_SLTU = 6'h2B;

    // ALU function codes {sub, mode[1:0], shift, math}
    localparam alufn_t ALU_ADD  = 5'b00001;
    localparam alufn_t ALU_SUB  = 5'b10001;
    localparam alufn_t ALU_AND  = 5'b00000;
    localparam alufn_t ALU_OR   = 5'b00100;
    localparam alufn_t ALU_XOR  = 5'b01000;
    localparam alufn_t ALU_NOR  = 5'b01100;
    localparam alufn_t ALU_LT   = 5'b10011;
    localparam alufn_t ALU_LTU  = 5'b10111;
    localparam alufn_t ALU_SHL  = 5'b00010;
    localparam alufn_t ALU_SHR  = 5'b00110;
    localparam alufn_t ALU_SRA  = 5'b01110;

    // Next-PC choices
    localparam pcsel_t PC_SEQ   = 3'd0;
    localparam pcsel_t PC_BR    = 3'd1;
    localparam pcsel_t PC_JMP   = 3'd2;
    localparam pcsel_t PC_REG   = 3'd3;
    localparam pcsel_t PC_RST   = 3'd4;
    localparam pcsel_t PC_BAD   = 3'd5;
    localparam pcsel_t PC_IRQ   = 3'd6;

    // Write address / data / operand choices
    localparam sel_t WA_RD  = 2'd0;
    localparam sel_t WA_RT  = 2'd1;
    localparam sel_t WA_R31 = 2'd2;
    localparam sel_t WA_R27 = 2'd3;
    localparam sel_t WD_LINK = 2'd0;
    localparam sel_t WD_ALU  = 2'd1;
    localparam sel_t WD_MEM  = 2'd2;
    localparam sel_t A_RS    = 2'd0;
    localparam sel_t A_SHAMT = 2'd1;
    localparam sel_t A_K16   = 2'd2;

    typedef enum logic [1:0] {
        BR_NONE = 2'd0,
        BR_EQ   = 2'd1,
        BR_NE   = 2'd2
    } br_kind_t;

    typedef struct packed {
        pcsel_t pc_sel;
        logic   sext;
        sel_t   wa_sel;
        sel_t   wd_sel;
        alufn_t alu_fn;
        logic   mem_we;
        logic   rf_we;
        sel_t   a_sel;
        logic   b_sel;
    } ctrl_t;

    localparam ctrl_t CTRL_ZERO = '0;

endpackage

// File: rtl/scdec_table.sv
// Module: opcode/function table. Maps the opcode and function fields to a
// base control word, a branch kind and a bad-encoding flag. Assumes the
// branch outcome and all overrides are applied downstream.
module scdec_table
    import scdec_pkg::*;
(
    input  op_t      op,
    input  fn_t      fn,
    output ctrl_t    base,
    output br_kind_t br,
    output logic     bad
);

    ctrl_t    c;
    br_kind_t b;
    logic     inv;

    // Decode one instruction into its base control word.
    always_comb begin
        c   = CTRL_ZERO;
        b   = BR_NONE;
        inv = 1'b0;
        unique case (op)
            OP_RTYPE: begin
                c.wa_sel = WA_RD;
                c.wd_sel = WD_ALU;
                c.rf_we  = 1'b1;
                case (fn)
                    FN_ADD, FN_ADDU: c.alu_fn = ALU_ADD;
                    FN_SUB, FN_SUBU: c.alu_fn = ALU_SUB;
                    FN_AND:  c.alu_fn = ALU_AND;
                    FN_OR:   c.alu_fn = ALU_OR;
                    FN_XOR:  c.alu_fn = ALU_XOR;
                    FN_NOR:  c.alu_fn = ALU_NOR;
                    FN_SLT:  c.alu_fn = ALU_LT;
                    FN_SLTU: c.alu_fn = ALU_LTU;
                    FN_SLL: begin c.alu_fn = ALU_SHL; c.a_sel = A_SHAMT; end
                    FN_SRL: begin c.alu_fn = ALU_SHR; c.a_sel = A_SHAMT; end
                    FN_SRA: begin c.alu_fn = ALU_SRA; c.a_sel = A_SHAMT; end
                    FN_SLLV: c.alu_fn = ALU_SHL;
                    FN_SRLV: c.alu_fn = ALU_SHR;
                    FN_SRAV: c.alu_fn = ALU_SRA;
                    FN_JR: begin
                        c.pc_sel = PC_REG;
                        c.wd_sel = WD_LINK;
                        c.rf_we  = 1'b0;
                    end
                    FN_JALR: begin
                        c.pc_sel = PC_REG;
                        c.wd_sel = WD_LINK;
                    end
                    default: inv = 1'b1;
                endcase
            end
            OP_ADDI, OP_ADDIU, OP_SLTI, OP_SLTIU,
            OP_ANDI, OP_ORI, OP_XORI: begin
                c.wa_sel = WA_RT;
                c.wd_sel = WD_ALU;
                c.rf_we  = 1'b1;
                c.b_sel  = 1'b1;
                c.sext   = 1'b1;
                case (op)
                    OP_SLTI:  c.alu_fn = ALU_LT;
                    OP_SLTIU: c.alu_fn = ALU_LTU;
                    OP_ANDI: begin c.alu_fn = ALU_AND; c.sext = 1'b0; end
                    OP_ORI:  begin c.alu_fn = ALU_OR;  c.sext = 1'b0; end
                    OP_XORI: begin c.alu_fn = ALU_XOR; c.sext = 1'b0; end
                    default:  c.alu_fn = ALU_ADD;
                endcase
            end
            OP_LUI: begin
                c.wa_sel = WA_RT;
                c.wd_sel = WD_ALU;
                c.rf_we  = 1'b1;
                c.b_sel  = 1'b1;
                c.a_sel  = A_K16;
                c.alu_fn = ALU_SHL;
            end
            OP_LOAD: begin
                c.wa_sel = WA_RT;
                c.wd_sel = WD_MEM;
                c.rf_we  = 1'b1;
                c.b_sel  = 1'b1;
                c.sext   = 1'b1;
                c.alu_fn = ALU_ADD;
            end
            OP_STORE: begin
                c.mem_we = 1'b1;
                c.b_sel  = 1'b1;
                c.sext   = 1'b1;
                c.alu_fn = ALU_ADD;
            end
            OP_BEQ, OP_BNE: begin
                c.sext   = 1'b1;
                c.alu_fn = ALU_SUB;
                b        = (op == OP_BEQ) ? BR_EQ : BR_NE;
            end
            OP_JMP: c.pc_sel = PC_JMP;
            OP_JAL: begin
                c.pc_sel = PC_JMP;
                c.wa_sel = WA_R31;
                c.wd_sel = WD_LINK;
                c.rf_we  = 1'b1;
            end
            default: inv = 1'b1;
        endcase
    end

    assign base = c;
    assign br   = b;
    assign bad  = inv;

endmodule

// File: rtl/scdec_branch.sv
// Module: branch resolution. Replaces the next-PC choice with the branch
// target when the zero flag satisfies the branch kind. Assumes the zero
// flag comes from A-B of the same instruction.
module scdec_branch
    import scdec_pkg::*;
(
    input  br_kind_t br,
    input  logic     zero,
    input  pcsel_t   pc_in,
    output pcsel_t   pc_out
);

    logic taken;

    // Evaluate the condition for the current branch kind.
    always_comb begin
        unique case (br)
            BR_EQ:   taken = zero;
            BR_NE:   taken = ~zero;
            default: taken = 1'b0;
        endcase
    end

    assign pc_out = taken ? PC_BR : pc_in;

endmodule

// File: rtl/scdec_priority.sv
// Module: priority override. Reset wins over interrupt, interrupt over a
// bad encoding, and that over the normal decode. Assumes rst_n is the
// processor reset used as a data input.
module scdec_priority
    import scdec_pkg::*;
(
    input  logic  rst_n,
    input  logic  irq,
    input  logic  bad,
    input  ctrl_t norm,
    output ctrl_t ctrl
);

    // Build the trap word for an interrupt or a bad encoding.
    function automatic ctrl_t trap_word(input pcsel_t vec);
        ctrl_t t;
        t        = CTRL_ZERO;
        t.pc_sel = vec;
        t.wa_sel = WA_R27;
        t.wd_sel = WD_LINK;
        t.rf_we  = 1'b1;
        return t;
    endfunction

    // Select the final control word by priority.
    always_comb begin
        ctrl = norm;
        if (!rst_n) begin
            ctrl        = CTRL_ZERO;
            ctrl.pc_sel = PC_RST;
        end else if (irq) begin
            ctrl = trap_word(PC_IRQ);
        end else if (bad) begin
            ctrl = trap_word(PC_BAD);
        end
    end

endmodule

// File: rtl/scdec_top.sv
// Module: single-cycle instruction control decoder top. Purely combinational;
// splits the word, runs the table, resolves branches and applies overrides.
module scdec_top
    import scdec_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    input  logic               rst_n,
    input  logic               irq,
    input  logic               alu_zero,
    output logic [PCSEL_W-1:0] pc_sel,
    output logic               sext,
    output logic [SEL_W-1:0]   wa_sel,
    output logic [SEL_W-1:0]   wd_sel,
    output logic [ALUFN_W-1:0] alu_fn,
    output logic               mem_we,
    output logic               rf_we,
    output logic [SEL_W-1:0]   a_sel,
    output logic               b_sel
);

    op_t      op;
    fn_t      fn;
    ctrl_t    base;
    ctrl_t    resolved;
    ctrl_t    final_c;
    br_kind_t br;
    logic     bad;
    pcsel_t   pc_res;
    logic     unused_fields;

    assign op = instr[OP_HI:OP_LO];
    assign fn = instr[FN_W-1:0];
    assign unused_fields = ^instr[OP_LO-1:FN_W];

    scdec_table u_table (
        .op   (op),
        .fn   (fn),
        .base (base),
        .br   (br),
        .bad  (bad)
    );

    scdec_branch u_branch (
        .br     (br),
        .zero   (alu_zero),
        .pc_in  (base.pc_sel),
        .pc_out (pc_res)
    );

    // Merge the resolved next-PC choice back into the base word.
    always_comb begin
        resolved        = base;
        resolved.pc_sel = pc_res;
    end

    scdec_priority u_prio (
        .rst_n (rst_n),
        .irq   (irq),
        .bad   (bad),
        .norm  (resolved),
        .ctrl  (final_c)
    );

    assign pc_sel = final_c.pc_sel;
    assign sext   = final_c.sext;
    assign wa_sel = final_c.wa_sel;
    assign wd_sel = final_c.wd_sel;
    assign alu_fn = final_c.alu_fn;
    assign mem_we = final_c.mem_we;
    assign rf_we  = final_c.rf_we;
    assign a_sel  = final_c.a_sel;
    assign b_sel  = final_c.b_sel;

endmodule

// File: rtl/scdec_checker.sv
// Module: port-level checker bound to scdec_top. Combinational rules on the
// outputs against the inputs; no state, so immediate assertions are used.
module scdec_checker (
    input logic [31:0] instr,
    input logic        rst_n,
    input logic        irq,
    input logic        alu_zero,
    input logic [2:0]  pc_sel,
    input logic [1:0]  wa_sel,
    input logic [1:0]  wd_sel,
    input logic        mem_we,
    input logic        rf_we
);

    // Check priority, trap and data-path consistency rules.
    always_comb begin
        if (!rst_n) begin
            AST_RESET_WINS: assert (pc_sel == 3'd4 && !mem_we && !rf_we); // R1
        end
        if (rst_n && irq) begin
            AST_IRQ_LINK: assert (pc_sel == 3'd6 && wa_sel == 2'd3 && wd_sel == 2'd0 && rf_we && !mem_we); // R2
        end
        if (pc_sel == 3'd5) begin
            AST_BAD_LINK: assert (wa_sel == 2'd3 && rf_we && !mem_we); // R3
        end
        if (mem_we) begin
            AST_STORE_NO_WRITE: assert (!rf_we && pc_sel == 3'd0); // R8
        end
        if (rst_n && !irq && instr[31:26] == 6'h04) begin
            AST_BEQ_FOLLOWS_ZERO: assert (pc_sel == (alu_zero ? 3'd1 : 3'd0)); // R9
        end
        if (rst_n && !irq && instr[31:26] == 6'h05) begin
            AST_BNE_FOLLOWS_ZERO: assert (pc_sel == (alu_zero ? 3'd0 : 3'd1)); // R9
        end
        if (wa_sel == 2'd2) begin
            AST_R31_ONLY_JAL: assert (pc_sel == 3'd2 && wd_sel == 2'd0 && rf_we); // R10
        end
    end

endmodule

bind scdec_top scdec_checker u_chk (
    .instr    (instr),
    .rst_n    (rst_n),
    .irq      (irq),
    .alu_zero (alu_zero),
    .pc_sel   (pc_sel),
    .wa_sel   (wa_sel),
    .wd_sel   (wd_sel),
    .mem_we   (mem_we),
    .rf_we    (rf_we)
);

// File: tb/scdec_top_tb.sv
// Bench: directed corners plus seeded random words, compared to a model
// built from the requirements.
module scdec_top_tb;

    logic        clk = 1'b0;
    logic [31:0] instr = '0;
    logic        rst_n = 1'b0;
    logic        irq = 1'b0;
    logic        alu_zero = 1'b0;
    logic [2:0]  pc_sel;
    logic        sext;
    logic [1:0]  wa_sel, wd_sel, a_sel;
    logic [4:0]  alu_fn;
    logic        mem_we, rf_we, b_sel;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    scdec_top u_dut (
        .instr(instr), .rst_n(rst_n), .irq(irq), .alu_zero(alu_zero),
        .pc_sel(pc_sel), .sext(sext), .wa_sel(wa_sel), .wd_sel(wd_sel),
        .alu_fn(alu_fn), .mem_we(mem_we), .rf_we(rf_we), .a_sel(a_sel),
        .b_sel(b_sel)
    );

    // Pack fields as {pc, sext, wa, wd, fn, mem_we, rf_we, a, b}.
    function automatic logic [17:0] mk(input logic [2:0] pc, input logic sx,
        input logic [1:0] wa, input logic [1:0] wd, input logic [4:0] fn,
        input logic mw, input logic rw, input logic [1:0] a, input logic b);
        return {pc, sx, wa, wd, fn, mw, rw, a, b};
    endfunction

    // Expected control word from the requirements.
    function automatic logic [17:0] model(input logic [31:0] w, input logic rn,
                                          input logic iq, input logic z);
        logic [5:0] op = w[31:26];
        logic [5:0] f  = w[5:0];
        logic [17:0] trap_bad = mk(3'd5, 0, 2'd3, 2'd0, 5'b0, 0, 1, 2'd0, 0); // R3
        if (!rn) return mk(3'd4, 0, 0, 0, 5'b0, 0, 0, 0, 0);                  // R1
        if (iq)  return mk(3'd6, 0, 2'd3, 2'd0, 5'b0, 0, 1, 0, 0);            // R2
        case (op)
            6'h00: case (f) // R4 R5 R11
                6'h20, 6'h21: return mk(0, 0, 0, 1, 5'b00001, 0, 1, 0, 0);
                6'h22, 6'h23: return mk(0, 0, 0, 1, 5'b10001, 0, 1, 0, 0);
                6'h24: return mk(0, 0, 0, 1, 5'b00000, 0, 1, 0, 0);
                6'h25: return mk(0, 0, 0, 1, 5'b00100, 0, 1, 0, 0);
                6'h26: return mk(0, 0, 0, 1, 5'b01000, 0, 1, 0, 0);
                6'h27: return mk(0, 0, 0, 1, 5'b01100, 0, 1, 0, 0);
                6'h2A: return mk(0, 0, 0, 1, 5'b10011, 0, 1, 0, 0);
                6'h2B: return mk(0, 0, 0, 1, 5'b10111, 0, 1, 0, 0);
                6'h00: return mk(0, 0, 0, 1, 5'b00010, 0, 1, 1, 0);
                6'h02: return mk(0, 0, 0, 1, 5'b00110, 0, 1, 1, 0);
                6'h03: return mk(0, 0, 0, 1, 5'b01110, 0, 1, 1, 0);
                6'h04: return mk(0, 0, 0, 1, 5'b00010, 0, 1, 0, 0);
                6'h06: return mk(0, 0, 0, 1, 5'b00110, 0, 1, 0, 0);
                6'h07: return mk(0, 0, 0, 1, 5'b01110, 0, 1, 0, 0);
                6'h08: return mk(3, 0, 0, 0, 5'b0, 0, 0, 0, 0);
                6'h09: return mk(3, 0, 0, 0, 5'b0, 0, 1, 0, 0);
                default: return trap_bad;
            endcase
            6'h08, 6'h09: return mk(0, 1, 1, 1, 5'b00001, 0, 1, 0, 1); // R6
            6'h0A: return mk(0, 1, 1, 1, 5'b10011, 0, 1, 0, 1);
            6'h0B: return mk(0, 1, 1, 1, 5'b10111, 0, 1, 0, 1);
            6'h0C: return mk(0, 0, 1, 1, 5'b00000, 0, 1, 0, 1);
            6'h0D: return mk(0, 0, 1, 1, 5'b00100, 0, 1, 0, 1);
            6'h0E: return mk(0, 0, 1, 1, 5'b01000, 0, 1, 0, 1);
            6'h0F: return mk(0, 0, 1, 1, 5'b00010, 0, 1, 2, 1);        // R7
            6'h23: return mk(0, 1, 1, 2, 5'b00001, 0, 1, 0, 1);        // R8
            6'h2B: return mk(0, 1, 0, 0, 5'b00001, 1, 0, 0, 1);
            6'h04: return mk(z ? 3'd1 : 3'd0, 1, 0, 0, 5'b10001, 0, 0, 0, 0); // R9
            6'h05: return mk(z ? 3'd0 : 3'd1, 1, 0, 0, 5'b10001, 0, 0, 0, 0);
            6'h02: return mk(2, 0, 0, 0, 5'b0, 0, 0, 0, 0);            // R10
            6'h03: return mk(2, 0, 2, 0, 5'b0, 0, 1, 0, 0);
            default: return trap_bad;
        endcase
    endfunction

    // Drive one stimulus, wait, compare the whole control word.
    task automatic apply(input logic [31:0] w, input logic rn, input logic iq,
                         input logic z, input string req);
        logic [17:0] exp, act;
        @(negedge clk);
        instr = w; rst_n = rn; irq = iq; alu_zero = z;
        #5;
        exp = model(w, rn, iq, z);
        act = {pc_sel, sext, wa_sel, wd_sel, alu_fn, mem_we, rf_we, a_sel, b_sel};
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s instr=%08h rst_n=%0b irq=%0b z=%0b act=%05h exp=%05h",
                     req, w, rn, iq, z, act, exp);
        end
    endtask

    function automatic logic [31:0] rtype(input logic [5:0] f);
        return {6'h00, $urandom_range(0, 32'h000F_FFFF) & 32'hFFFFF, f};
    endfunction

    function automatic logic [31:0] itype(input logic [5:0] o);
        logic [25:0] rest = 26'($urandom);
        return {o, rest};
    endfunction

    initial begin
        logic [5:0] valid_fn [18] = '{6'h20,6'h21,6'h22,6'h23,6'h24,6'h25,6'h26,
            6'h27,6'h2A,6'h2B,6'h00,6'h02,6'h03,6'h04,6'h06,6'h07,6'h08,6'h09};
        logic [5:0] valid_op [14] = '{6'h02,6'h03,6'h04,6'h05,6'h08,6'h09,6'h0A,
            6'h0B,6'h0C,6'h0D,6'h0E,6'h0F,6'h23,6'h2B};
        void'($urandom(32'd1234));

        // Reset state and reset priority
        apply(32'h0000_0020, 0, 0, 0, "R1");
        apply(32'hAC00_0000, 0, 1, 1, "R1");
        apply(32'hFFFF_FFFF, 0, 1, 0, "R1");
        // Interrupt over normal and bad encodings
        apply(32'hAC22_0004, 1, 1, 0, "R2");
        apply(32'hFC00_0000, 1, 1, 1, "R2");
        // Bad encodings
        apply(32'hFC00_0000, 1, 0, 0, "R3");
        apply(32'h0000_0001, 1, 0, 0, "R3");
        apply(32'h0000_003F, 1, 0, 1, "R3");
        // Directed per class
        apply(32'h0022_1820, 1, 0, 0, "R4");
        apply(32'h0022_182A, 1, 0, 0, "R4");
        apply(32'h0002_1880, 1, 0, 0, "R5");
        apply(32'h0022_1807, 1, 0, 0, "R5");
        apply(32'h3022_FFFF, 1, 0, 0, "R6");
        apply(32'h2022_FFFF, 1, 0, 0, "R6");
        apply(32'h3C01_1234, 1, 0, 0, "R7");
        apply(32'h8C22_0004, 1, 0, 0, "R8");
        apply(32'hAC22_0004, 1, 0, 1, "R8");
        apply(32'h1022_0003, 1, 0, 1, "R9");
        apply(32'h1022_0003, 1, 0, 0, "R9");
        apply(32'h1422_0003, 1, 0, 1, "R9");
        apply(32'h1422_0003, 1, 0, 0, "R9");
        apply(32'h0800_0100, 1, 0, 0, "R10");
        apply(32'h0C00_0100, 1, 0, 1, "R10");
        apply(32'h0020_0008, 1, 0, 0, "R11");
        apply(32'h0020_F809, 1, 0, 0, "R11");

        // Every valid encoding against both flag values (R12 full-word compare)
        foreach (valid_fn[i]) begin
            apply(rtype(valid_fn[i]), 1, 0, 0, "R12");
            apply(rtype(valid_fn[i]), 1, 0, 1, "R12");
        end
        foreach (valid_op[i]) begin
            apply(itype(valid_op[i]), 1, 0, 0, "R12");
            apply(itype(valid_op[i]), 1, 0, 1, "R12");
        end

        // Seeded random mix: valid picks and raw words, all input combinations
        for (int k = 0; k < 3000; k++) begin
            logic [31:0] w;
            logic rn, iq, z;
            case ($urandom_range(0, 2))
                0: w = rtype(valid_fn[$urandom_range(0, 17)]);
                1: w = itype(valid_op[$urandom_range(0, 13)]);
                default: w = $urandom;
            endcase
            rn = ($urandom_range(0, 9) != 0);
            iq = ($urandom_range(0, 7) == 0);
            z  = 1'($urandom);
            apply(w, rn, iq, z, "R1-R12 random");
        end
        done = 1'b1;
    end

    // Watchdog and summary
    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_fail++;
                $display("FAIL watchdog expired act=running exp=done");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule